// File: doc/BRIEF.md
# Interrupt Halt Classifier and Pin Masker

This block collects interrupt events for a controller in which a script engine runs next to a DMA unit and a bus-protocol unit. Each source delivers a one-cycle pulse. The block latches that pulse into a sticky status bit, which stays set until software reads the status word with a read-to-clear strobe. Each status bit has its own enable bit.

Every pending event is classified as fatal or nonfatal. Any pending DMA event is fatal. A protocol event is nonfatal only when two conditions hold:

- it belongs to a small set of routine events, and that set is slightly larger in target role than in initiator role;
- its enable bit is clear.

Setting the enable bit of a routine event makes it fatal. While any fatal event is pending, a level halt request goes to the script engine.

An active-low interrupt pin reports enabled pending events. A global mask bit can hold the pin deasserted without touching the pending status.

Top module: `irq_halt_classifier`

## Requirements
- R1: After synchronous reset, both status words, both enable words and the pin mask are zero, the role is initiator, `halt_req` is 0 and `irq_n` is 1.
- R2: A pulse on a source bit sets that status bit after the clock edge. The bit holds until the clear strobe of its own word. A clear strobe zeroes only its own word. A source pulse in the same cycle as the clear strobe leaves its bit set.
- R3: Any set bit of `dma_status` drives `halt_req` to 1, whatever the DMA enable word holds.
- R4: In initiator role (`role_target`=0), protocol status bits 0 to 4 are nonfatal while their enable bits are clear. Those bits are: 0 function complete, 1 selected, 2 reselected, 3 general timer expired, 4 handshake timer expired. Every other protocol bit, bit 5 (attention active) included, drives `halt_req` to 1.
- R5: In target role (`role_target`=1), protocol bit 5 joins the nonfatal set, so bits 0 to 5 are nonfatal while their enables are clear.
- R6: A pending protocol bit whose enable bit is set is fatal in either role and drives `halt_req` to 1.
- R7: `irq_n` is 0 exactly when some status bit is set together with its enable bit and the pin mask is 0. While the mask is 1, `irq_n` stays 1 and the status words keep their values.
- R8: When the pin mask is written to 0 while an enabled event is pending, `irq_n` goes low in the cycle right after the write.
- R9: `top_status[0]` is the OR of `dma_status`, and `top_status[1]` is the OR of `prot_status`.
- R10: The `role_target` input is registered. A change re-classifies events that are already pending, and the new `halt_req` value appears in the cycle after the change.
- R11: `halt_req` is a level. It stays at 1 until no fatal-qualified status bit is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_src_pulse | input | DMA_W | One-cycle DMA event pulses |
| prot_src_pulse | input | PROT_W | One-cycle protocol event pulses |
| dma_en_we | input | 1 | Write strobe for the DMA enable word |
| dma_en_wdata | input | DMA_W | New DMA enable word |
| prot_en_we | input | 1 | Write strobe for the protocol enable word |
| prot_en_wdata | input | PROT_W | New protocol enable word |
| pin_mask_we | input | 1 | Write strobe for the global pin mask |
| pin_mask_wdata | input | 1 | New pin mask value (1 = pin held off) |
| role_target | input | 1 | Operating role: 0 initiator, 1 target |
| dma_clr | input | 1 | Read-to-clear strobe for the DMA status word |
| prot_clr | input | 1 | Read-to-clear strobe for the protocol status word |
| dma_status | output | DMA_W | Latched DMA status bits |
| prot_status | output | PROT_W | Latched protocol status bits |
| top_status | output | 2 | Summary: bit 0 DMA pending, bit 1 protocol pending |
| halt_req | output | 1 | Level halt request to the script engine |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
Every cycle, the bound checker confirms the following:

- a pending DMA bit and an enabled pending protocol bit both hold the halt request;
- a mask of 1 keeps the pin high;
- a low pin always has an enabled pending cause;
- status bits only grow between clear strobes, and a source pulse always lands in its status bit;
- the halt request drops only after a clear, an enable write or a role change.

The exact role-dependent nonfatal sets, the set-over-clear race, the one-cycle latency of a role change and the one-cycle pin assertion after unmasking depend on specific input sequences. The bench's directed scenarios cover those, sampling the outputs both just before and just after the relevant clock edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Protocol status bit positions that the role classification decodes
    localparam int unsigned PB_FUNC_DONE = 0;
    localparam int unsigned PB_SELECTED  = 1;
    localparam int unsigned PB_RESELECT  = 2;
    localparam int unsigned PB_GEN_TIMER = 3;
    localparam int unsigned PB_HS_TIMER  = 4;
    localparam int unsigned PB_ATTENTION = 5;

    // Upper bound on the protocol word width supported by the class map
    localparam int unsigned PROT_W_MAX = 32;

    typedef enum logic {
        ROLE_INITIATOR = 1'b0,
        ROLE_TARGET    = 1'b1
    } role_e;

    typedef struct packed {
        logic prot_pend;
        logic dma_pend;
    } summary_t;

    typedef struct packed {
        logic dma_fatal;
        logic prot_fatal;
    } fatal_src_t;

    // Bits that may stay nonfatal (when their enable is clear) for a role
    function automatic logic [PROT_W_MAX-1:0] nonfatal_map(input role_e role);
        logic [PROT_W_MAX-1:0] m;
        m = '0;
        m[PB_FUNC_DONE] = 1'b1;
        m[PB_SELECTED]  = 1'b1;
        m[PB_RESELECT]  = 1'b1;
        m[PB_GEN_TIMER] = 1'b1;
        m[PB_HS_TIMER]  = 1'b1;
        if (role == ROLE_TARGET) begin
            m[PB_ATTENTION] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_pulse,
    input  logic         clr,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable
);

    logic [W-1:0] status_q;
    logic [W-1:0] enable_q;

    // One sticky cell per source: a set pulse dominates the clear strobe
    for (genvar i = 0; i < W; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[i] <= 1'b0;
            end else if (src_pulse[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (en_we) begin
            enable_q <= en_wdata;
        end
    end

    assign status = status_q;
    assign enable = enable_q;

endmodule

// File: rtl/irqc_classifier.sv
module irqc_classifier
    import irqc_pkg::*;
#(
    parameter int unsigned DMA_W  = 8,
    parameter int unsigned PROT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_in,
    input  logic [DMA_W-1:0]  dma_status,
    input  logic [PROT_W-1:0] prot_status,
    input  logic [PROT_W-1:0] prot_en,
    output role_e             role_q,
    output logic              halt_req
);

    logic [PROT_W_MAX-1:0] nf_full;
    logic [PROT_W-1:0]     nf_role;
    logic [PROT_W-1:0]     prot_fatal_bits;
    fatal_src_t            fatal;

    // Role is registered so that a change re-classifies on the next cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            role_q <= ROLE_INITIATOR;
        end else begin
            role_q <= role_e'(role_in);
        end
    end

    always_comb begin
        nf_full = nonfatal_map(role_q);
        nf_role = nf_full[PROT_W-1:0];
    end

    // A protocol bit qualifies as fatal unless it is nonfatal for the
    // current role and its enable bit is clear
    for (genvar i = 0; i < PROT_W; i++) begin : g_qual
        assign prot_fatal_bits[i] = prot_status[i] & (prot_en[i] | ~nf_role[i]);
    end

    always_comb begin
        fatal.dma_fatal  = |dma_status;
        fatal.prot_fatal = |prot_fatal_bits;
        halt_req         = fatal.dma_fatal | fatal.prot_fatal;
    end

endmodule

// File: rtl/irqc_pin_ctrl.sv
module irqc_pin_ctrl #(
    parameter int unsigned DMA_W  = 8,
    parameter int unsigned PROT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              mask_wdata,
    input  logic [DMA_W-1:0]  dma_status,
    input  logic [DMA_W-1:0]  dma_en,
    input  logic [PROT_W-1:0] prot_status,
    input  logic [PROT_W-1:0] prot_en,
    output logic              mask_q,
    output logic              irq_n
);

    logic enabled_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    // The mask only gates the pin; pending state is held in the banks
    always_comb begin
        enabled_pending = (|(dma_status & dma_en)) | (|(prot_status & prot_en));
        irq_n           = ~(enabled_pending & ~mask_q);
    end

endmodule

// File: rtl/irq_halt_classifier.sv
module irq_halt_classifier
    import irqc_pkg::*;
#(
    parameter int unsigned DMA_W  = 8,
    parameter int unsigned PROT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DMA_W-1:0]  dma_src_pulse,
    input  logic [PROT_W-1:0] prot_src_pulse,
    input  logic              dma_en_we,
    input  logic [DMA_W-1:0]  dma_en_wdata,
    input  logic              prot_en_we,
    input  logic [PROT_W-1:0] prot_en_wdata,
    input  logic              pin_mask_we,
    input  logic              pin_mask_wdata,
    input  logic              role_target,
    input  logic              dma_clr,
    input  logic              prot_clr,
    output logic [DMA_W-1:0]  dma_status,
    output logic [PROT_W-1:0] prot_status,
    output logic [1:0]        top_status,
    output logic              halt_req,
    output logic              irq_n
);

    logic [DMA_W-1:0]  dma_en_q;
    logic [PROT_W-1:0] prot_en_q;
    logic              mask_q;
    role_e             role_q;
    summary_t          summary;

    irqc_status_bank #(.W(DMA_W)) u_dma_bank (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (dma_src_pulse),
        .clr       (dma_clr),
        .en_we     (dma_en_we),
        .en_wdata  (dma_en_wdata),
        .status    (dma_status),
        .enable    (dma_en_q)
    );

    irqc_status_bank #(.W(PROT_W)) u_prot_bank (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (prot_src_pulse),
        .clr       (prot_clr),
        .en_we     (prot_en_we),
        .en_wdata  (prot_en_wdata),
        .status    (prot_status),
        .enable    (prot_en_q)
    );

    irqc_classifier #(.DMA_W(DMA_W), .PROT_W(PROT_W)) u_class (
        .clk         (clk),
        .rst         (rst),
        .role_in     (role_target),
        .dma_status  (dma_status),
        .prot_status (prot_status),
        .prot_en     (prot_en_q),
        .role_q      (role_q),
        .halt_req    (halt_req)
    );

    irqc_pin_ctrl #(.DMA_W(DMA_W), .PROT_W(PROT_W)) u_pin (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (pin_mask_we),
        .mask_wdata  (pin_mask_wdata),
        .dma_status  (dma_status),
        .dma_en      (dma_en_q),
        .prot_status (prot_status),
        .prot_en     (prot_en_q),
        .mask_q      (mask_q),
        .irq_n       (irq_n)
    );

    always_comb begin
        summary.dma_pend  = |dma_status;
        summary.prot_pend = |prot_status;
        top_status        = summary;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned DMA_W  = 8,
    parameter int unsigned PROT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DMA_W-1:0]  dma_src_pulse,
    input logic [PROT_W-1:0] prot_src_pulse,
    input logic              dma_clr,
    input logic              prot_clr,
    input logic              prot_en_we,
    input logic              role_target,
    input logic              role_q,
    input logic              mask_q,
    input logic [DMA_W-1:0]  dma_en_q,
    input logic [PROT_W-1:0] prot_en_q,
    input logic [DMA_W-1:0]  dma_status,
    input logic [PROT_W-1:0] prot_status,
    input logic [1:0]        top_status,
    input logic              halt_req,
    input logic              irq_n
);

    // R2
    dma_set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_src_pulse != '0) |=> ((dma_status & $past(dma_src_pulse)) == $past(dma_src_pulse)));

    // R2
    prot_set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_src_pulse != '0) |=> ((prot_status & $past(prot_src_pulse)) == $past(prot_src_pulse)));

    // R2
    prot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !prot_clr |=> ((prot_status & $past(prot_status)) == $past(prot_status)));

    // R3
    dma_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_status != '0) |-> halt_req);

    // R4
    init_fatal_chk: assert property (@(posedge clk) disable iff (rst)
        (!role_q && (prot_status[PROT_W-1:5] != '0)) |-> halt_req);

    // R6
    enabled_fatal_chk: assert property (@(posedge clk) disable iff (rst)
        ((prot_status & prot_en_q) != '0) |-> halt_req);

    // R7
    mask_pin_chk: assert property (@(posedge clk) disable iff (rst)
        mask_q |-> irq_n);

    // R7
    pin_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (((dma_status & dma_en_q) != '0) || ((prot_status & prot_en_q) != '0)));

    // R9
    summary_chk: assert property (@(posedge clk) disable iff (rst)
        (top_status[0] == (dma_status != '0)) && (top_status[1] == (prot_status != '0)));

    // R11
    halt_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_req) |-> ($past(dma_clr) || $past(prot_clr) || $past(prot_en_we)
                             || ($past(role_target) != $past(role_q))));

endmodule

bind irq_halt_classifier irqc_checker #(.DMA_W(DMA_W), .PROT_W(PROT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dma_src_pulse  (dma_src_pulse),
    .prot_src_pulse (prot_src_pulse),
    .dma_clr        (dma_clr),
    .prot_clr       (prot_clr),
    .prot_en_we     (prot_en_we),
    .role_target    (role_target),
    .role_q         (role_q),
    .mask_q         (mask_q),
    .dma_en_q       (dma_en_q),
    .prot_en_q      (prot_en_q),
    .dma_status     (dma_status),
    .prot_status    (prot_status),
    .top_status     (top_status),
    .halt_req       (halt_req),
    .irq_n          (irq_n)
);

// File: tb/irq_halt_classifier_tb.sv
`timescale 1ns/1ps
module irq_halt_classifier_tb;

    localparam int unsigned DMA_W  = 8;
    localparam int unsigned PROT_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DMA_W-1:0]  dma_src_pulse = '0;
    logic [PROT_W-1:0] prot_src_pulse = '0;
    logic              dma_en_we = 1'b0;
    logic [DMA_W-1:0]  dma_en_wdata = '0;
    logic              prot_en_we = 1'b0;
    logic [PROT_W-1:0] prot_en_wdata = '0;
    logic              pin_mask_we = 1'b0;
    logic              pin_mask_wdata = 1'b0;
    logic              role_target = 1'b0;
    logic              dma_clr = 1'b0;
    logic              prot_clr = 1'b0;
    logic [DMA_W-1:0]  dma_status;
    logic [PROT_W-1:0] prot_status;
    logic [1:0]        top_status;
    logic              halt_req;
    logic              irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_halt_classifier #(.DMA_W(DMA_W), .PROT_W(PROT_W)) u_dut (
        .clk, .rst, .dma_src_pulse, .prot_src_pulse, .dma_en_we, .dma_en_wdata,
        .prot_en_we, .prot_en_wdata, .pin_mask_we, .pin_mask_wdata, .role_target,
        .dma_clr, .prot_clr, .dma_status, .prot_status, .top_status, .halt_req, .irq_n
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        dma_src_pulse = '0; prot_src_pulse = '0;
        dma_en_we = 0; prot_en_we = 0; pin_mask_we = 0;
        role_target = 0; dma_clr = 0; prot_clr = 0;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
    endtask

    task automatic pulse_dma(input logic [DMA_W-1:0] v);
        dma_src_pulse = v; cyc(); dma_src_pulse = '0;
    endtask

    task automatic pulse_prot(input logic [PROT_W-1:0] v);
        prot_src_pulse = v; cyc(); prot_src_pulse = '0;
    endtask

    task automatic clr_dma();
        dma_clr = 1; cyc(); dma_clr = 0;
    endtask

    task automatic clr_prot();
        prot_clr = 1; cyc(); prot_clr = 0;
    endtask

    task automatic wr_prot_en(input logic [PROT_W-1:0] v);
        prot_en_we = 1; prot_en_wdata = v; cyc(); prot_en_we = 0;
    endtask

    task automatic wr_dma_en(input logic [DMA_W-1:0] v);
        dma_en_we = 1; dma_en_wdata = v; cyc(); dma_en_we = 0;
    endtask

    task automatic wr_mask(input logic v);
        pin_mask_we = 1; pin_mask_wdata = v; cyc(); pin_mask_we = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "dma_status", 32'(dma_status), 0);
        chk("R1", "prot_status", 32'(prot_status), 0);
        chk("R1", "halt_req", 32'(halt_req), 0);
        chk("R1", "irq_n", 32'(irq_n), 1);
    endtask

    task automatic t_sticky();
        do_reset();
        pulse_dma(8'h04);
        chk("R2", "dma set", 32'(dma_status), 32'h04);
        cyc(); cyc(); cyc();
        chk("R2", "dma held", 32'(dma_status), 32'h04);
        pulse_prot(16'h0200);
        clr_dma();
        chk("R2", "dma cleared", 32'(dma_status), 0);
        chk("R2", "prot untouched by dma_clr", 32'(prot_status), 32'h0200);
        clr_prot();
        chk("R2", "prot cleared", 32'(prot_status), 0);
    endtask

    task automatic t_race();
        do_reset();
        pulse_prot(16'h0003);
        prot_clr = 1; prot_src_pulse = 16'h0002; cyc();
        prot_clr = 0; prot_src_pulse = '0;
        chk("R2", "set wins over clear", 32'(prot_status), 32'h0002);
    endtask

    task automatic t_dma_fatal();
        do_reset();
        pulse_dma(8'h20);
        chk("R3", "halt with dma enable clear", 32'(halt_req), 1);
        chk("R7", "pin idle when not enabled", 32'(irq_n), 1);
        cyc(); cyc();
        chk("R11", "halt level held", 32'(halt_req), 1);
        clr_dma();
        chk("R11", "halt released", 32'(halt_req), 0);
    endtask

    task automatic t_initiator();
        do_reset();
        for (int b = 0; b < 5; b++) begin
            pulse_prot(PROT_W'(1) << b);
            chk("R4", $sformatf("bit %0d nonfatal", b), 32'(halt_req), 0);
            clr_prot();
        end
        pulse_prot(16'h0020);
        chk("R4", "attention fatal in initiator", 32'(halt_req), 1);
        clr_prot();
        pulse_prot(16'h1000);
        chk("R4", "bit 12 fatal", 32'(halt_req), 1);
        clr_prot();
    endtask

    task automatic t_target();
        do_reset();
        role_target = 1; cyc();
        pulse_prot(16'h0020);
        chk("R5", "attention nonfatal in target", 32'(halt_req), 0);
        pulse_prot(16'h0001);
        chk("R5", "bit 0 nonfatal in target", 32'(halt_req), 0);
        pulse_prot(16'h0080);
        chk("R5", "bit 7 fatal in target", 32'(halt_req), 1);
    endtask

    task automatic t_enable();
        do_reset();
        wr_prot_en(16'h0001);
        pulse_prot(16'h0004);
        chk("R6", "unenabled bit 2 nonfatal", 32'(halt_req), 0);
        pulse_prot(16'h0001);
        chk("R6", "enabled bit 0 fatal", 32'(halt_req), 1);
        chk("R7", "enabled bit drives pin", 32'(irq_n), 0);
        do_reset();
        role_target = 1; cyc();
        wr_prot_en(16'h0020);
        pulse_prot(16'h0020);
        chk("R6", "enabled attention fatal in target", 32'(halt_req), 1);
    endtask

    task automatic t_mask();
        do_reset();
        wr_dma_en(8'h01);
        pulse_dma(8'h01);
        chk("R7", "dma enabled pin low", 32'(irq_n), 0);
        clr_dma();
        wr_prot_en(16'h0008);
        wr_mask(1'b1);
        pulse_prot(16'h0008);
        chk("R7", "masked pin high", 32'(irq_n), 1);
        cyc();
        chk("R7", "status kept under mask", 32'(prot_status), 32'h0008);
        chk("R6", "halt while masked", 32'(halt_req), 1);
        pin_mask_we = 1; pin_mask_wdata = 0;
        #1;
        chk("R8", "pin still high before edge", 32'(irq_n), 1);
        cyc(); pin_mask_we = 0;
        chk("R8", "pin low cycle after unmask", 32'(irq_n), 0);
    endtask

    task automatic t_summary();
        do_reset();
        pulse_dma(8'h80);
        chk("R9", "dma summary", 32'(top_status), 32'h1);
        pulse_prot(16'h0002);
        chk("R9", "both summary", 32'(top_status), 32'h3);
        clr_dma();
        chk("R9", "prot summary only", 32'(top_status), 32'h2);
    endtask

    task automatic t_role();
        do_reset();
        pulse_prot(16'h0020);
        chk("R10", "initiator halts on attention", 32'(halt_req), 1);
        role_target = 1;
        #1;
        chk("R10", "no change before edge", 32'(halt_req), 1);
        cyc();
        chk("R10", "reclassified after edge", 32'(halt_req), 0);
        chk("R10", "status kept across role", 32'(prot_status), 32'h0020);
        role_target = 0; cyc();
        chk("R10", "back to fatal", 32'(halt_req), 1);
    endtask

    task automatic t_level();
        do_reset();
        dma_src_pulse = 8'h01; prot_src_pulse = 16'h0400; cyc();
        dma_src_pulse = '0; prot_src_pulse = '0;
        clr_dma();
        chk("R11", "halt held by remaining fatal bit", 32'(halt_req), 1);
        clr_prot();
        chk("R11", "halt drops when none left", 32'(halt_req), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sticky();
        t_race();
        t_dma_fatal();
        t_initiator();
        t_target();
        t_enable();
        t_mask();
        t_summary();
        t_role();
        t_level();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule